// File: doc/BRIEF.md
# Speculative Store Buffer with Checkpoint Gating

This block sits between a processor's store port and the memory write port. In normal operation, stores pass straight through to memory. Once a checkpoint is requested, every later store is held inside the block as an address/data entry and memory is not touched. A store to an address that is already held replaces that entry's data in place. Loads can look up an address and receive the buffered value, so speculative stores are forwarded.

A commit request drains the held entries to memory one per accepted handshake, oldest allocation first, and then returns to normal operation. When an allocation uses the last free entry, the drain starts by itself. A rollback request throws away every held entry in a single cycle and leaves speculative mode without any memory traffic.

Top module: `spec_store_buf`

## Requirements
- R1: After reset the block is in normal mode: spec_active, draining, mem_valid (with st_valid low) and ld_hit are all 0.
- R2: In normal mode a store goes straight to memory in the same cycle: mem_valid equals st_valid, mem_addr/mem_data equal st_addr/st_data, and st_ready equals mem_ready.
- R3: A ckpt_req pulse in normal mode sets spec_active from the next cycle on. From then on stores are accepted with st_ready high and mem_valid stays low.
- R4: A speculative store whose address is already held overwrites that entry's data and allocates nothing, so the later drain emits a single write for that address, carrying the newest data.
- R5: ld_hit is 1 in the same cycle when ld_addr matches a held entry, and ld_data then carries that entry's newest data. For any other address ld_hit is 0.
- R6: After commit_req, draining is 1 from the next cycle. Entries go to memory in allocation order, one per cycle in which mem_valid and mem_ready are both high. Each entry holds mem_addr/mem_data steady while mem_ready is low, and st_ready is 0 throughout. When the drain ends, the block returns to normal mode.
- R7: A speculative store that allocates the last of DEPTH entries starts the drain in the next cycle without a commit_req.
- R8: A rollback_req in speculative mode wins over commit_req and over a store in the same cycle; st_ready is 0 in that cycle. In the next cycle the block is back in normal mode with no entry held (ld_hit 0) and no memory write made.
- R9: A commit_req with no entries held returns to normal mode in the next cycle without any memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| st_ready | output | 1 | Store accepted this cycle |
| ld_addr | input | ADDR_W | Load lookup address |
| ld_hit | output | 1 | Lookup matched a held entry |
| ld_data | output | DATA_W | Forwarded data on a hit |
| ckpt_req | input | 1 | Enter speculative mode |
| commit_req | input | 1 | Write held entries to memory |
| rollback_req | input | 1 | Discard held entries |
| spec_active | output | 1 | Speculative mode or draining |
| draining | output | 1 | Commit drain in progress |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Memory write address |
| mem_data | output | DATA_W | Memory write data |

## Verification
The store path is exercised in both modes. Pass-through stores separate a direct path from a buffered one, and a repeated address within one checkpoint separates in-place coalescing from a fresh allocation. Drains are run both with memory back-pressure and without it, which exposes reordering and unstable outputs. A fill to exactly DEPTH distinct addresses checks the forced commit, and a rollback raised together with a store checks priority and that memory stays silent. An empty commit covers the degenerate drain.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_SPEC  = 2'd1,
        MODE_DRAIN = 2'd2
    } ssb_mode_e;
endpackage

// File: rtl/ssb_cam.sv
module ssb_cam #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 2
) (
    input  logic [DEPTH-1:0]             vld,
    input  logic [DEPTH-1:0][ADDR_W-1:0] tags,
    input  logic [ADDR_W-1:0]            key,
    output logic [DEPTH-1:0]             match,
    output logic                         hit,
    output logic [IDX_W-1:0]             idx
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = vld[g] && (tags[g] == key);
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/spec_store_buf.sv
module spec_store_buf
    import ssb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_hit,
    output logic [DATA_W-1:0] ld_data,
    input  logic              ckpt_req,
    input  logic              commit_req,
    input  logic              rollback_req,
    output logic              spec_active,
    output logic              draining,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        ssb_mode_e                    mode;
        logic [CW-1:0]                cnt;
        logic [IW-1:0]                rd;
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0][DATA_W-1:0] data;
    } state_t;

    state_t s_d, s_q;

    logic [DEPTH-1:0] st_match, ld_match;
    logic             st_hit, ld_hit_w;
    logic [IW-1:0]    st_idx, ld_idx;
    logic [IW-1:0]    wr_idx;

    ssb_cam #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IW)) i_st_cam (
        .vld(s_q.vld), .tags(s_q.addr), .key(st_addr),
        .match(st_match), .hit(st_hit), .idx(st_idx)
    );

    ssb_cam #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IW)) i_ld_cam (
        .vld(s_q.vld), .tags(s_q.addr), .key(ld_addr),
        .match(ld_match), .hit(ld_hit_w), .idx(ld_idx)
    );

    assign wr_idx      = s_q.cnt[IW-1:0];
    assign ld_hit      = ld_hit_w;
    assign ld_data     = ld_hit_w ? s_q.data[ld_idx] : '0;
    assign spec_active = (s_q.mode != MODE_IDLE);
    assign draining    = (s_q.mode == MODE_DRAIN);

    // Port-side outputs per mode
    always_comb begin
        st_ready  = 1'b0;
        mem_valid = 1'b0;
        mem_addr  = st_addr;
        mem_data  = st_data;
        case (s_q.mode)
            MODE_IDLE: begin
                st_ready  = mem_ready;
                mem_valid = st_valid;
            end
            MODE_SPEC: begin
                st_ready  = !rollback_req && !commit_req;
            end
            MODE_DRAIN: begin
                mem_valid = 1'b1;
                mem_addr  = s_q.addr[s_q.rd];
                mem_data  = s_q.data[s_q.rd];
            end
            default: ;
        endcase
    end

    // Next-state computation
    always_comb begin
        s_d = s_q;
        case (s_q.mode)
            MODE_IDLE: begin
                if (ckpt_req) s_d.mode = MODE_SPEC;
            end
            MODE_SPEC: begin
                if (rollback_req) begin
                    s_d.vld  = '0;
                    s_d.cnt  = '0;
                    s_d.rd   = '0;
                    s_d.mode = MODE_IDLE;
                end else if (commit_req) begin
                    s_d.rd   = '0;
                    s_d.mode = (s_q.cnt == '0) ? MODE_IDLE : MODE_DRAIN;
                end else if (st_valid) begin
                    if (st_hit) begin
                        s_d.data[st_idx] = st_data;
                    end else begin
                        s_d.vld[wr_idx]  = 1'b1;
                        s_d.addr[wr_idx] = st_addr;
                        s_d.data[wr_idx] = st_data;
                        s_d.cnt          = s_q.cnt + 1'b1;
                        if (s_q.cnt + 1'b1 == CW'(DEPTH)) begin
                            s_d.rd   = '0;
                            s_d.mode = MODE_DRAIN;
                        end
                    end
                end
            end
            MODE_DRAIN: begin
                if (mem_ready) begin
                    s_d.vld[s_q.rd] = 1'b0;
                    if (CW'(s_q.rd) + 1'b1 == s_q.cnt) begin
                        s_d.cnt  = '0;
                        s_d.rd   = '0;
                        s_d.mode = MODE_IDLE;
                    end else begin
                        s_d.rd = s_q.rd + 1'b1;
                    end
                end
            end
            default: s_d.mode = MODE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3
    no_spec_leak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MODE_SPEC) |-> !mem_valid);

    // R4
    unique_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld_match) && $onehot0(st_match));

    // R6
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (draining && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    // R6
    drain_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        draining |-> !st_ready);

    // R7
    full_forces_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == CW'(DEPTH)) |-> draining);

    // R8
    rollback_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MODE_SPEC && rollback_req) |=> (s_q.vld == '0 && !spec_active));
endmodule

// File: tb/test_spec_store_buf.sv
module test_spec_store_buf;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_valid = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic st_ready;
    logic [AW-1:0] ld_addr = '0;
    logic ld_hit;
    logic [DW-1:0] ld_data;
    logic ckpt_req = 1'b0, commit_req = 1'b0, rollback_req = 1'b0;
    logic spec_active, draining, mem_valid;
    logic mem_ready = 1'b1;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;

    int checks = 0;
    int errors = 0;
    logic [AW+DW-1:0] exp_q[$];

    always #5 clk = ~clk;

    spec_store_buf #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) i_spec_store_buf (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
        .st_data(st_data), .st_ready(st_ready), .ld_addr(ld_addr), .ld_hit(ld_hit),
        .ld_data(ld_data), .ckpt_req(ckpt_req), .commit_req(commit_req),
        .rollback_req(rollback_req), .spec_active(spec_active), .draining(draining),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Monitor: every memory handshake must match the scoreboard head
    always @(negedge clk) begin
        if (rst_n && mem_valid && mem_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8/R9 unexpected write", {mem_addr, mem_data}, 0);
            end else begin
                logic [AW+DW-1:0] e;
                e = exp_q.pop_front();
                chk({mem_addr, mem_data} == e, "R4/R6 write order/data", {mem_addr, mem_data}, e);
            end
        end
    end

    // Driver: present one store for a cycle, optionally expecting a memory write
    task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit expect_wr);
        st_valid = 1'b1; st_addr = a; st_data = d;
        if (expect_wr) exp_q.push_back({a, d});
        @(negedge clk);
        if (spec_active) chk(st_ready === 1'b1 && mem_valid === 1'b0, "R3 buffered store", {st_ready, mem_valid}, 2'b10);
        tick();
        st_valid = 1'b0;
    endtask

    task automatic pulse_ckpt();
        ckpt_req = 1'b1; tick(); ckpt_req = 1'b0;
    endtask

    task automatic wait_idle();
        while (spec_active) @(negedge clk);
        tick();
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!spec_active && !draining && !mem_valid && !ld_hit, "R1 reset state",
            {spec_active, draining, mem_valid, ld_hit}, 0);
        tick();

        // R2 pass-through, ready low then high
        mem_ready = 1'b0; st_valid = 1'b1; st_addr = 16'h0010; st_data = 32'hAAAA0001;
        @(negedge clk);
        chk(mem_valid && !st_ready && mem_addr == 16'h0010 && mem_data == 32'hAAAA0001,
            "R2 pass-through stalled", {mem_valid, st_ready}, 2'b10);
        tick();
        mem_ready = 1'b1;
        exp_q.push_back({16'h0010, 32'hAAAA0001});
        @(negedge clk);
        chk(st_ready === 1'b1, "R2 ready follows memory", st_ready, 1);
        tick(); st_valid = 1'b0;

        // R3, R4, R5: checkpoint, coalesce, forward
        pulse_ckpt();
        @(negedge clk);
        chk(spec_active === 1'b1, "R3 checkpoint entered", spec_active, 1);
        tick();
        store(16'h0020, 32'h11, 0);
        store(16'h0021, 32'h22, 0);
        store(16'h0020, 32'h33, 0);
        ld_addr = 16'h0020;
        @(negedge clk);
        chk(ld_hit && ld_data == 32'h33, "R5 forward newest data", ld_data, 32'h33);
        ld_addr = 16'h0099;
        @(negedge clk);
        chk(!ld_hit, "R5 lookup miss", ld_hit, 0);
        tick();

        // R6 commit with back-pressure
        exp_q.push_back({16'h0020, 32'h33});
        exp_q.push_back({16'h0021, 32'h22});
        mem_ready = 1'b0;
        commit_req = 1'b1; tick(); commit_req = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(draining && mem_valid && mem_addr == 16'h0020 && !st_ready,
                "R6 drain holds head", mem_addr, 16'h0020);
        end
        tick();
        mem_ready = 1'b1;
        wait_idle();
        chk(exp_q.size() == 0, "R4/R6 single coalesced write each", exp_q.size(), 0);

        // R7 forced drain when full
        pulse_ckpt();
        for (int i = 0; i < DEPTH; i++) store(16'h0100 + 16'(i), 32'h500 + 32'(i), 0);
        for (int i = 0; i < DEPTH; i++) exp_q.push_back({16'h0100 + 16'(i), 32'h500 + 32'(i)});
        @(negedge clk);
        chk(draining === 1'b1 && st_ready === 1'b0, "R7 full forces drain", draining, 1);
        wait_idle();
        chk(exp_q.size() == 0, "R7 all entries written", exp_q.size(), 0);

        // R8 rollback wins over store and commit
        pulse_ckpt();
        store(16'h0030, 32'h77, 0);
        store(16'h0031, 32'h78, 0);
        st_valid = 1'b1; st_addr = 16'h0032; st_data = 32'h79;
        rollback_req = 1'b1; commit_req = 1'b1;
        @(negedge clk);
        chk(st_ready === 1'b0, "R8 store refused on rollback", st_ready, 0);
        tick();
        st_valid = 1'b0; rollback_req = 1'b0; commit_req = 1'b0;
        ld_addr = 16'h0030;
        @(negedge clk);
        chk(!spec_active && !ld_hit && !mem_valid, "R8 discarded", {spec_active, ld_hit}, 0);
        tick(); tick();

        // R9 empty commit
        pulse_ckpt();
        commit_req = 1'b1; tick(); commit_req = 1'b0;
        @(negedge clk);
        chk(!spec_active && !draining && !mem_valid, "R9 empty commit", {spec_active, draining}, 0);
        tick(); tick();

        // Back in normal mode, pass-through again (R2)
        store(16'h0040, 32'hBEEF, 1);
        tick();
        chk(exp_q.size() == 0, "R2 pass-through after rollback", exp_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule